// File: doc/BRIEF.md
# Segment Access Fault Classifier

This block checks one memory operand reference per cycle against the cached attributes of the segment it targets. It looks at the segment's type bits, limit, present flag and role (stack, task state, other). When one or more checks fail, it reports a single protected-mode exception number. It also reports whether an error code must be pushed, what that code is, and whether the faulting instruction may be restarted. The result appears on registered outputs one clock after the request.

The block sits between the address generation stage and the exception sequencer. Address generation presents the offset, the operand size, the access kind and the descriptor cache contents of the selected segment. The exception sequencer takes the registered verdict and builds the stack frame from it. A multi-register push or pop is flagged together with the stack pointer value saved at instruction start. A stack overrun during such a push or pop whose saved pointer sits at the very edge of the 16-bit space cannot be resumed.

Top module: `segflt_top`

## Requirements
- R1: Outputs are registered: a request sampled at a rising edge with `reqValid` high is reported after that edge. `faultValid` is 1 only when at least one check fails. When `faultValid` is 0, `faultVector`, `errPush`, `errCode` and `restartable` are all 0, including out of reset.
- R2: A write (`reqKind` = 1) to a code segment (`segCode` = 1) reports vector 13, with the selector as error code, not restartable.
- R3: A read (`reqKind` = 0) from a code segment whose `segRdWr` is 0 (execute-only) reports vector 13, not restartable. A read from a code segment with `segRdWr` = 1 passes. An execute fetch (`reqKind` = 2) from a data segment (`segCode` = 0) reports vector 13. The unused kind 3 is always a vector 13 fault.
- R4: A write to a data segment whose `segRdWr` is 0 (read-only) reports vector 13, not restartable. A write to a data segment with `segRdWr` = 1 passes.
- R5: The last byte touched is `reqOffset` + `reqWord`, taken modulo 65536. If the offset or that last byte exceeds `segLimit`, the request faults. For the stack segment the fault is vector 12 with error code 0, restartable. For any other segment it is vector 13 with the selector as error code, restartable.
- R6: The carry out of the last-byte sum is dropped. A word access at offset FFFFh with limit FFFFh therefore passes.
- R7: A segment with `segPresent` = 0 reports vector 11, or vector 12 when `segIsStack` = 1. The error code is the selector, and the fault is restartable.
- R8: A stack limit fault during a multi-register push/pop (`multiPush` = 1) is not restartable when `savedSp` is 0000h, 0001h, FFFEh or FFFFh. It remains restartable for any other `savedSp` value.
- R9: A task state segment (`segIsTss` = 1) whose limit is 002Bh or less reports vector 10, with the selector as error code, not restartable. A limit of 002Ch passes this check.
- R10: When several checks fail, the reported fault follows this priority: not-present first, then the task state limit check, then the segment limit check, then the type check.
- R11: Every reported fault (vectors 10 to 13) has `errPush` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A reference is presented this cycle |
| reqKind | input | 2 | 0 read, 1 write, 2 execute, 3 unused |
| reqOffset | input | 16 | Effective offset of the first byte |
| reqWord | input | 1 | 1 for a two-byte operand, 0 for one byte |
| segCode | input | 1 | Segment is a code segment |
| segRdWr | input | 1 | Code: readable; data: writable |
| segPresent | input | 1 | Segment present flag |
| segIsStack | input | 1 | Segment is the current stack segment |
| segIsTss | input | 1 | Segment is a task state segment |
| segLimit | input | 16 | Highest valid offset |
| segSelector | input | 16 | Selector of the segment, used as error code |
| multiPush | input | 1 | Reference belongs to a multi-register push/pop |
| savedSp | input | 16 | Stack pointer saved at instruction start |
| faultValid | output | 1 | A fault is reported |
| faultVector | output | 4 | Exception number (10 to 13) |
| errPush | output | 1 | An error code must be pushed |
| errCode | output | 16 | Error code value |
| restartable | output | 1 | Faulting instruction can be resumed |

## Verification
The only state is the output register, so any internal error appears one clock after the request that exposes it. Three kinds of corruption are distinguishable at the ports: a wrong priority choice, a wrong comparison in the last-byte or stack-edge logic, and a wrong selection of the error code. Each shows up as a wrong vector, a wrong restart flag or a swapped error code on the very next cycle. The directed cases pair each boundary with its passing neighbour: limit equal to the last byte, TSS limit 2Bh versus 2Ch, and stack pointer 0001h versus 0002h. An off-by-one in any of these comparisons therefore changes a visible output.

// File: rtl/segflt_pkg.sv
package segflt_pkg;

  localparam int VEC_W = 4;

  localparam logic [VEC_W-1:0] VEC_NONE = 4'd0;
  localparam logic [VEC_W-1:0] VEC_TSS  = 4'd10;
  localparam logic [VEC_W-1:0] VEC_NP   = 4'd11;
  localparam logic [VEC_W-1:0] VEC_SS   = 4'd12;
  localparam logic [VEC_W-1:0] VEC_GP   = 4'd13;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_BAD   = 2'd3
  } accKind_t;

  // check outcomes passed from datapath to control
  typedef struct packed {
    logic notPresent;
    logic tssBad;
    logic limitBad;
    logic typeBad;
    logic stackSeg;
    logic spWrap;
  } chkFlags_t;

endpackage

// File: rtl/segflt_dp.sv
module segflt_dp
  import segflt_pkg::*;
#(
  parameter int OFS_W = 16,
  parameter int TSS_MIN_LIMIT = 43,
  parameter int WRAP_SLACK = 2
) (
  input  logic [1:0]       reqKind,
  input  logic [OFS_W-1:0] reqOffset,
  input  logic             reqWord,
  input  logic             segCode,
  input  logic             segRdWr,
  input  logic             segPresent,
  input  logic             segIsStack,
  input  logic             segIsTss,
  input  logic [OFS_W-1:0] segLimit,
  input  logic             multiPush,
  input  logic [OFS_W-1:0] savedSp,
  output chkFlags_t        flags
);

  localparam logic [OFS_W-1:0] TSS_LIM   = OFS_W'(TSS_MIN_LIMIT);
  localparam logic [OFS_W-1:0] ALL_ONES  = {OFS_W{1'b1}};

  logic [OFS_W-1:0] lastByte;
  logic             limitBad;
  logic             typeBad;
  logic [WRAP_SLACK-1:0] lowHit;
  logic [WRAP_SLACK-1:0] highHit;

  // carry out of the sum is dropped on purpose
  assign lastByte = reqOffset + {{(OFS_W-1){1'b0}}, reqWord};
  assign limitBad = (reqOffset > segLimit) || (lastByte > segLimit);

  always_comb begin
    unique case (accKind_t'(reqKind))
      ACC_READ:  typeBad = segCode & ~segRdWr;
      ACC_WRITE: typeBad = segCode | ~segRdWr;
      ACC_EXEC:  typeBad = ~segCode;
      default:   typeBad = 1'b1;
    endcase
  end

  // stack pointer values at the edges of the offset space
  for (genvar i = 0; i < WRAP_SLACK; i++) begin : gWrap
    assign lowHit[i]  = (savedSp == OFS_W'(i));
    assign highHit[i] = (savedSp == (ALL_ONES - OFS_W'(i)));
  end

  assign flags.notPresent = ~segPresent;
  assign flags.tssBad     = segIsTss && (segLimit <= TSS_LIM);
  assign flags.limitBad   = limitBad;
  assign flags.typeBad    = typeBad;
  assign flags.stackSeg   = segIsStack;
  assign flags.spWrap     = multiPush && ((|lowHit) || (|highHit));

endmodule

// File: rtl/segflt_ctl.sv
module segflt_ctl
  import segflt_pkg::*;
#(
  parameter int OFS_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  chkFlags_t        flags,
  input  logic [OFS_W-1:0] segSelector,
  output logic             faultValid,
  output logic [VEC_W-1:0] faultVector,
  output logic             errPush,
  output logic [OFS_W-1:0] errCode,
  output logic             restartable
);

  logic             nxtValid;
  logic [VEC_W-1:0] nxtVector;
  logic [OFS_W-1:0] nxtCode;
  logic             nxtRestart;

  // priority: not-present, TSS limit, segment limit, type
  always_comb begin
    nxtValid   = 1'b0;
    nxtVector  = VEC_NONE;
    nxtCode    = '0;
    nxtRestart = 1'b0;
    if (reqValid) begin
      if (flags.notPresent) begin
        nxtValid   = 1'b1;
        nxtVector  = flags.stackSeg ? VEC_SS : VEC_NP;
        nxtCode    = segSelector;
        nxtRestart = 1'b1;
      end else if (flags.tssBad) begin
        nxtValid   = 1'b1;
        nxtVector  = VEC_TSS;
        nxtCode    = segSelector;
      end else if (flags.limitBad) begin
        nxtValid   = 1'b1;
        if (flags.stackSeg) begin
          nxtVector  = VEC_SS;
          nxtRestart = ~flags.spWrap;
        end else begin
          nxtVector  = VEC_GP;
          nxtCode    = segSelector;
          nxtRestart = 1'b1;
        end
      end else if (flags.typeBad) begin
        nxtValid   = 1'b1;
        nxtVector  = VEC_GP;
        nxtCode    = segSelector;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      faultValid  <= 1'b0;
      faultVector <= VEC_NONE;
      errPush     <= 1'b0;
      errCode     <= '0;
      restartable <= 1'b0;
    end else begin
      faultValid  <= nxtValid;
      faultVector <= nxtVector;
      errPush     <= nxtValid;
      errCode     <= nxtCode;
      restartable <= nxtRestart;
    end
  end

endmodule

// File: rtl/segflt_top.sv
module segflt_top
  import segflt_pkg::*;
#(
  parameter int OFS_W = 16,
  parameter int TSS_MIN_LIMIT = 43,
  parameter int WRAP_SLACK = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [1:0]       reqKind,
  input  logic [OFS_W-1:0] reqOffset,
  input  logic             reqWord,
  input  logic             segCode,
  input  logic             segRdWr,
  input  logic             segPresent,
  input  logic             segIsStack,
  input  logic             segIsTss,
  input  logic [OFS_W-1:0] segLimit,
  input  logic [OFS_W-1:0] segSelector,
  input  logic             multiPush,
  input  logic [OFS_W-1:0] savedSp,
  output logic             faultValid,
  output logic [3:0]       faultVector,
  output logic             errPush,
  output logic [OFS_W-1:0] errCode,
  output logic             restartable
);

  chkFlags_t flags;

  segflt_dp #(
    .OFS_W(OFS_W),
    .TSS_MIN_LIMIT(TSS_MIN_LIMIT),
    .WRAP_SLACK(WRAP_SLACK)
  ) uDp (
    .reqKind(reqKind),
    .reqOffset(reqOffset),
    .reqWord(reqWord),
    .segCode(segCode),
    .segRdWr(segRdWr),
    .segPresent(segPresent),
    .segIsStack(segIsStack),
    .segIsTss(segIsTss),
    .segLimit(segLimit),
    .multiPush(multiPush),
    .savedSp(savedSp),
    .flags(flags)
  );

  segflt_ctl #(.OFS_W(OFS_W)) uCtl (
    .clk(clk),
    .rstN(rstN),
    .reqValid(reqValid),
    .flags(flags),
    .segSelector(segSelector),
    .faultValid(faultValid),
    .faultVector(faultVector),
    .errPush(errPush),
    .errCode(errCode),
    .restartable(restartable)
  );

endmodule

// File: rtl/segflt_chk.sv
module segflt_chk #(
  parameter int OFS_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             segPresent,
  input logic             segIsStack,
  input logic             segIsTss,
  input logic [OFS_W-1:0] segLimit,
  input logic [OFS_W-1:0] reqOffset,
  input logic             multiPush,
  input logic [OFS_W-1:0] savedSp,
  input logic             faultValid,
  input logic [3:0]       faultVector,
  input logic             errPush,
  input logic             restartable
);

  // R1
  fault_needs_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |-> $past(reqValid));

  // R1
  quiet_outputs_chk: assert property (@(posedge clk) disable iff (!rstN)
    !faultValid |-> (faultVector == 4'd0 && !errPush && !restartable));

  // R11
  err_push_chk: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |-> errPush);

  // R7
  np_stack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !segPresent && segIsStack) |=>
      (faultValid && faultVector == 4'd12 && restartable));

  // R7
  np_other_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !segPresent && !segIsStack) |=>
      (faultValid && faultVector == 4'd11 && restartable));

  // R9
  tss_short_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && segPresent && segIsTss && segLimit <= OFS_W'(43)) |=>
      (faultVector == 4'd10 && !restartable));

  // R8
  stack_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && segPresent && !segIsTss && segIsStack && multiPush &&
     savedSp == '0 && reqOffset > segLimit) |=>
      (faultVector == 4'd12 && !restartable));

endmodule

bind segflt_top segflt_chk #(.OFS_W(OFS_W)) uChk (
  .clk(clk),
  .rstN(rstN),
  .reqValid(reqValid),
  .segPresent(segPresent),
  .segIsStack(segIsStack),
  .segIsTss(segIsTss),
  .segLimit(segLimit),
  .reqOffset(reqOffset),
  .multiPush(multiPush),
  .savedSp(savedSp),
  .faultValid(faultValid),
  .faultVector(faultVector),
  .errPush(errPush),
  .restartable(restartable)
);

// File: tb/sim_segflt_top.sv
module sim_segflt_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] SEL = 16'h0123;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqKind = 2'd0;
  logic [15:0] reqOffset = '0;
  logic        reqWord = 1'b0;
  logic        segCode = 1'b0;
  logic        segRdWr = 1'b1;
  logic        segPresent = 1'b1;
  logic        segIsStack = 1'b0;
  logic        segIsTss = 1'b0;
  logic [15:0] segLimit = 16'hFFFF;
  logic [15:0] segSelector = SEL;
  logic        multiPush = 1'b0;
  logic [15:0] savedSp = 16'h0100;
  logic        faultValid;
  logic [3:0]  faultVector;
  logic        errPush;
  logic [15:0] errCode;
  logic        restartable;

  int vecCount = 0;
  int missCount = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  segflt_top u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqOffset(reqOffset), .reqWord(reqWord), .segCode(segCode),
    .segRdWr(segRdWr), .segPresent(segPresent), .segIsStack(segIsStack),
    .segIsTss(segIsTss), .segLimit(segLimit), .segSelector(segSelector),
    .multiPush(multiPush), .savedSp(savedSp), .faultValid(faultValid),
    .faultVector(faultVector), .errPush(errPush), .errCode(errCode),
    .restartable(restartable)
  );

  task automatic checkOut(input string tag, input logic eV, input logic [3:0] eVec,
                          input logic [15:0] eCode, input logic eRst);
    vecCount++;
    if (faultValid !== eV || faultVector !== eVec || errPush !== eV ||
        errCode !== eCode || restartable !== eRst) begin
      missCount++;
      $display("FAIL %s: got v=%0d vec=%0d push=%0d code=%h rst=%0d, exp v=%0d vec=%0d push=%0d code=%h rst=%0d",
               tag, faultValid, faultVector, errPush, errCode, restartable,
               eV, eVec, eV, eCode, eRst);
    end
  endtask

  task automatic setSeg(input logic code, input logic rdwr, input logic pres,
                        input logic stk, input logic tss, input logic [15:0] lim);
    segCode = code; segRdWr = rdwr; segPresent = pres;
    segIsStack = stk; segIsTss = tss; segLimit = lim;
    multiPush = 1'b0; savedSp = 16'h0100;
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic applyReq(input logic [1:0] k, input logic [15:0] off, input logic w);
    reqKind = k; reqOffset = off; reqWord = w; reqValid = 1'b1;
    @(negedge clk);
  endtask

  task automatic testReset();
    checkOut("R1 reset state", 0, 4'd0, 16'h0, 0);
  endtask

  task automatic testClean();
    setSeg(0, 1, 1, 0, 0, 16'hFFFF);
    applyReq(2'd0, 16'h1000, 1);
    checkOut("R1 clean read", 0, 4'd0, 16'h0, 0);
  endtask

  task automatic testCodeWrite();
    setSeg(1, 1, 1, 0, 0, 16'hFFFF);
    applyReq(2'd1, 16'h0010, 0);
    checkOut("R2 write code seg", 1, 4'd13, SEL, 0);
  endtask

  task automatic testReadExec();
    setSeg(1, 0, 1, 0, 0, 16'hFFFF);
    applyReq(2'd0, 16'h0010, 0);
    checkOut("R3 read exec-only", 1, 4'd13, SEL, 0);
    applyReq(2'd2, 16'h0010, 0);
    checkOut("R3 fetch exec-only", 0, 4'd0, 16'h0, 0);
    setSeg(1, 1, 1, 0, 0, 16'hFFFF);
    applyReq(2'd0, 16'h0010, 1);
    checkOut("R3 read readable code", 0, 4'd0, 16'h0, 0);
    setSeg(0, 1, 1, 0, 0, 16'hFFFF);
    applyReq(2'd2, 16'h0010, 0);
    checkOut("R3 fetch from data", 1, 4'd13, SEL, 0);
    applyReq(2'd3, 16'h0010, 0);
    checkOut("R3 unused kind", 1, 4'd13, SEL, 0);
  endtask

  task automatic testRoWrite();
    setSeg(0, 0, 1, 0, 0, 16'hFFFF);
    applyReq(2'd1, 16'h0020, 1);
    checkOut("R4 write read-only", 1, 4'd13, SEL, 0);
    applyReq(2'd0, 16'h0020, 1);
    checkOut("R4 read read-only", 0, 4'd0, 16'h0, 0);
    setSeg(0, 1, 1, 0, 0, 16'hFFFF);
    applyReq(2'd1, 16'h0020, 1);
    checkOut("R4 write writable", 0, 4'd0, 16'h0, 0);
  endtask

  task automatic testLimit();
    setSeg(0, 1, 1, 0, 0, 16'h00FF);
    applyReq(2'd0, 16'h00FE, 1);
    checkOut("R5 word at limit edge", 0, 4'd0, 16'h0, 0);
    applyReq(2'd0, 16'h00FF, 1);
    checkOut("R5 word straddles limit", 1, 4'd13, SEL, 1);
    applyReq(2'd0, 16'h00FF, 0);
    checkOut("R5 byte at limit", 0, 4'd0, 16'h0, 0);
    setSeg(0, 1, 1, 1, 0, 16'h00FF);
    applyReq(2'd1, 16'h0100, 0);
    checkOut("R5 stack over limit", 1, 4'd12, 16'h0, 1);
  endtask

  task automatic testWrap();
    setSeg(0, 1, 1, 0, 0, 16'hFFFF);
    applyReq(2'd0, 16'hFFFF, 1);
    checkOut("R6 carry dropped", 0, 4'd0, 16'h0, 0);
  endtask

  task automatic testNotPresent();
    setSeg(0, 1, 0, 0, 0, 16'hFFFF);
    applyReq(2'd0, 16'h0000, 0);
    checkOut("R7 not present data", 1, 4'd11, SEL, 1);
    setSeg(0, 1, 0, 1, 0, 16'hFFFF);
    applyReq(2'd1, 16'h0000, 1);
    checkOut("R7 not present stack", 1, 4'd12, SEL, 1);
  endtask

  task automatic testStackWrap();
    setSeg(0, 1, 1, 1, 0, 16'h00FF);
    multiPush = 1'b1; savedSp = 16'hFFFE;
    applyReq(2'd1, 16'hFFFC, 1);
    checkOut("R8 sp FFFE", 1, 4'd12, 16'h0, 0);
    savedSp = 16'h0001;
    applyReq(2'd1, 16'hFFFC, 1);
    checkOut("R8 sp 0001", 1, 4'd12, 16'h0, 0);
    savedSp = 16'h0002;
    applyReq(2'd1, 16'hFFFC, 1);
    checkOut("R8 sp 0002", 1, 4'd12, 16'h0, 1);
    savedSp = 16'hFFFD;
    applyReq(2'd1, 16'hFFFC, 1);
    checkOut("R8 sp FFFD", 1, 4'd12, 16'h0, 1);
  endtask

  task automatic testTss();
    setSeg(0, 1, 1, 0, 1, 16'h002B);
    applyReq(2'd0, 16'h0000, 1);
    checkOut("R9 tss limit 2B", 1, 4'd10, SEL, 0);
    setSeg(0, 1, 1, 0, 1, 16'h002C);
    applyReq(2'd0, 16'h0000, 1);
    checkOut("R9 tss limit 2C", 0, 4'd0, 16'h0, 0);
  endtask

  task automatic testPriority();
    setSeg(1, 1, 0, 0, 0, 16'h0000);
    applyReq(2'd1, 16'h0100, 1);
    checkOut("R10 not-present first", 1, 4'd11, SEL, 1);
    setSeg(0, 1, 1, 0, 1, 16'h0010);
    applyReq(2'd0, 16'h0100, 1);
    checkOut("R10 tss before limit", 1, 4'd10, SEL, 0);
    setSeg(1, 1, 1, 0, 0, 16'h0010);
    applyReq(2'd1, 16'h0100, 1);
    checkOut("R10 limit before type", 1, 4'd13, SEL, 1);
  endtask

  task automatic testIdle();
    setSeg(1, 1, 1, 0, 0, 16'hFFFF);
    applyReq(2'd1, 16'h0000, 0);
    checkOut("R11 fault pushes code", 1, 4'd13, SEL, 0);
    reqValid = 1'b0;
    @(negedge clk);
    checkOut("R1 idle after fault", 0, 4'd0, 16'h0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    missCount++;
    $display("FAIL R1 watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testClean();
    testCodeWrite();
    testReadExec();
    testRoWrite();
    testLimit();
    testWrap();
    testNotPresent();
    testStackWrap();
    testTss();
    testPriority();
    testIdle();
    $display("  == %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

endmodule